// File: doc/BRIEF.md
# Serial Link Control Register Unit

This unit is the control front end of a vehicle serial bus controller. A CPU writes one control byte through a small address, write-strobe and read-data port. From that byte the unit derives four things: a clock-enable pulse that divides the crystal clock down to the interface timing rate, a receiver gate, a flag that selects binary or integer nominal timing, and an interrupt request masked by the enable bit and the ignore state.

The division field can be set once after reset and is locked after that. The ignore bit lets software drop the rest of a frame. While it is set, the receiver is gated off, the status flags seen by software read as zero, and no interrupt can reach the CPU. The receiver's start-of-frame and break detectors clear the bit again in hardware. Raw interrupt sources are level flags owned by the status logic. The request stays up while any one of them remains set.

Top module: `link_ctl_unit`

## Requirements
- R1: `tick_en` pulses high for one cycle in every 2^k cycles, where k is the rate field (codes 0 to 3 give division by 1, 2, 4 and 8). With code 0 it is high on every cycle after reset.
- R2: The first control write after reset loads the rate field and locks it. Later writes leave the rate and the tick period unchanged. Only reset clears the lock.
- R3: The clock-select bit (control bit 3) is stored and driven on `bin_timing`. A value of 1 means binary nominal timing and 0 means integer nominal timing.
- R4: Writing 1 to the ignore bit (control bit 4) drops `rx_enable` one cycle after the write edge. While the bit is set, `status_flags` reads as zero.
- R5: A pulse on `sof_det` or `brk_det` clears the ignore bit at that edge. This clear wins over a write of 1 in the same cycle. `status_flags` tracks the sources again from the next edge.
- R6: While the ignore bit is set, `irq` stays low whatever the enable bit, the mode and the sources are.
- R7: In run mode (`lp_mode`=0), `irq` follows the sources only when the interrupt-enable bit (control bit 0) is 1. With `lp_mode`=1, sources raise `irq` whether that bit is set or not.
- R8: `irq` rises one cycle after any unmasked source is set and stays high while at least one source remains set. It falls one cycle after the last source clears, or after the enable bit is cleared in run mode.
- R9: Reset clears every control bit and the lock. Read data is registered and appears one cycle after the address. At address 0 the layout is bit 0 enable, bits 2:1 rate, bit 3 clock select, bit 4 ignore, and the other bits 0. Other addresses read 0.
- R10: A change of the rate field restarts the divider. The first tick after the write edge appears 2^k + 1 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 2 | Register address |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| sof_det | input | 1 | Start-of-frame detected pulse |
| brk_det | input | 1 | Break symbol detected pulse |
| lp_mode | input | 1 | 1 while in stop or wait mode |
| src_flags | input | 3 | Raw interrupt source flags |
| tick_en | output | 1 | Divided interface clock enable |
| rx_enable | output | 1 | Receiver gate, low while ignoring |
| bin_timing | output | 1 | Binary nominal timing selected |
| status_flags | output | 3 | Source flags, forced to zero while ignoring |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions assume that `sof_det` and `brk_det` are pulses that never last long enough to block an ignore write that software means to take effect. The stimulus holds each pulse for a single cycle. The assertions also take the source flags to be levels that change only between edges. The bench drives every input on the falling edge, so each edge sees one stable source pattern. The rate-change assertion assumes that the rate moves only through the port. The stimulus changes it only by a first write after a fresh reset, and every later write only tries to move a field that is already locked.

// File: rtl/link_ctl_pkg.sv
package link_ctl_pkg;
  localparam int RATE_W = 2;
  typedef logic [RATE_W-1:0] rate_t;

  typedef struct packed {
    logic  locked;
    logic  ign;
    logic  clks;
    rate_t rate;
    logic  ie;
  } ctl_t;
endpackage

// File: rtl/lc_rate_div.sv
module lc_rate_div
  import link_ctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  rate_t rate,
  output logic  tick
);
  localparam int CNT_W = (1 << RATE_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  rate_t            rate_d;
  logic             chg;

  assign lim = CNT_W'((32'd1 << rate) - 32'd1);
  assign chg = (rate != rate_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_d <= '0;
    end else begin
      rate_d <= rate;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || chg) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && lim != '0 && !chg) |=> !tick);

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    chg |=> !tick);
endmodule

// File: rtl/lc_ctl_regs.sv
module lc_ctl_regs
  import link_ctl_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8,
  parameter int CTL_ADDR = 0,
  parameter int P_IE     = 0,
  parameter int P_RATE   = 1,
  parameter int P_CLKS   = 3,
  parameter int P_IGN    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              sof,
  input  logic              brk,
  output ctl_t              ctl
);
  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(CTL_ADDR);

  logic              sel;
  logic              hit;
  logic [DATA_W-1:0] img;
  logic              unused_wdata_bits;

  assign sel = (addr == SEL);
  assign hit = wr && sel;
  assign unused_wdata_bits = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else begin
      if (hit) begin
        ctl.ie   <= wdata[P_IE];
        ctl.clks <= wdata[P_CLKS];
        if (!ctl.locked) begin
          ctl.rate   <= wdata[P_RATE +: RATE_W];
          ctl.locked <= 1'b1;
        end
      end
      if (sof || brk) begin
        ctl.ign <= 1'b0;
      end else if (hit) begin
        ctl.ign <= wdata[P_IGN];
      end
    end
  end

  always_comb begin
    img                    = '0;
    img[P_IE]              = ctl.ie;
    img[P_RATE +: RATE_W]  = ctl.rate;
    img[P_CLKS]            = ctl.clks;
    img[P_IGN]             = ctl.ign;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= sel ? img : '0;
    end
  end

  // R2
  rate_lock_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.locked |=> (ctl.locked && $stable(ctl.rate)));

  // R5
  ign_autoclr_chk: assert property (@(posedge clk) disable iff (rst)
    (sof || brk) |=> !ctl.ign);
endmodule

// File: rtl/lc_irq_gate.sv
module lc_irq_gate #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ign,
  input  logic            ie,
  input  logic            lp_mode,
  input  logic [NSRC-1:0] src,
  output logic [NSRC-1:0] status,
  output logic            irq
);
  for (genvar i = 0; i < NSRC; i++) begin : g_stat
    always_ff @(posedge clk) begin
      if (rst || ign) begin
        status[i] <= 1'b0;
      end else begin
        status[i] <= src[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= !ign && (ie || lp_mode) && (|src);
    end
  end

  // R4
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ign |=> (status == '0));

  // R6
  ign_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ign |=> !irq);

  // R7
  run_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!ie && !lp_mode) |=> !irq);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ign && (ie || lp_mode) && src != '0) |=> irq);

  // R8
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (src == '0) |=> !irq);
endmodule

// File: rtl/link_ctl_unit.sv
module link_ctl_unit
  import link_ctl_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8,
  parameter int NSRC     = 3,
  parameter int CTL_ADDR = 0,
  parameter int P_IE     = 0,
  parameter int P_RATE   = 1,
  parameter int P_CLKS   = 3,
  parameter int P_IGN    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              sof_det,
  input  logic              brk_det,
  input  logic              lp_mode,
  input  logic [NSRC-1:0]   src_flags,
  output logic              tick_en,
  output logic              rx_enable,
  output logic              bin_timing,
  output logic [NSRC-1:0]   status_flags,
  output logic              irq
);
  ctl_t ctl;
  logic unused_lock;

  assign unused_lock = ctl.locked;

  lc_ctl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_ADDR(CTL_ADDR),
    .P_IE(P_IE), .P_RATE(P_RATE), .P_CLKS(P_CLKS), .P_IGN(P_IGN)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(cpu_addr), .wr(cpu_wr), .wdata(cpu_wdata),
    .rdata(cpu_rdata), .sof(sof_det), .brk(brk_det), .ctl(ctl)
  );

  lc_rate_div u_div (
    .clk(clk), .rst(rst), .rate(ctl.rate), .tick(tick_en)
  );

  lc_irq_gate #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst(rst), .ign(ctl.ign), .ie(ctl.ie), .lp_mode(lp_mode),
    .src(src_flags), .status(status_flags), .irq(irq)
  );

  assign rx_enable  = !ctl.ign;
  assign bin_timing = ctl.clks;
endmodule

// File: tb/link_ctl_unit_test.sv
module link_ctl_unit_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] cpu_addr;
  logic       cpu_wr;
  logic [7:0] cpu_wdata;
  logic [7:0] cpu_rdata;
  logic       sof_det, brk_det, lp_mode;
  logic [2:0] src_flags;
  logic       tick_en, rx_enable, bin_timing, irq;
  logic [2:0] status_flags;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  link_ctl_unit uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .sof_det(sof_det),
    .brk_det(brk_det), .lp_mode(lp_mode), .src_flags(src_flags),
    .tick_en(tick_en), .rx_enable(rx_enable), .bin_timing(bin_timing),
    .status_flags(status_flags), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] mk(input int ie, input int rate, input int clks, input int ign);
    return {3'b000, ign[0], clks[0], rate[1:0], ie[0]};
  endfunction

  task automatic do_reset();
    rst = 1'b1; cpu_addr = '0; cpu_wr = 1'b0; cpu_wdata = '0;
    sof_det = 1'b0; brk_det = 1'b0; lp_mode = 1'b0; src_flags = '0;
    cyc(3);
    rst = 1'b0;
    cyc(1);
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    cpu_addr = 2'd0; cpu_wdata = v; cpu_wr = 1'b1;
    cyc(1);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    cpu_addr = a;
    cyc(1);
    v = cpu_rdata;
    cpu_addr = 2'd0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    int first, second, cnt;

    // R9 reset state
    do_reset();
    rd(2'd0, rv);
    chk("R9 reset readback", rv, 0);
    chk("R9 reset rx_enable", rx_enable, 1);
    chk("R9 reset bin_timing", bin_timing, 0);
    chk("R9 reset irq", irq, 0);
    chk("R9 reset status", status_flags, 0);
    // R1 code 0: tick every cycle
    cnt = 0;
    for (int n = 0; n < 8; n++) begin cyc(1); cnt += tick_en; end
    chk("R1 div1 tick count", cnt, 8);
    // R2 code 0 locked
    wr_ctl(mk(0, 0, 0, 0));
    wr_ctl(mk(0, 2, 0, 0));
    cnt = 0;
    for (int n = 0; n < 8; n++) begin cyc(1); cnt += tick_en; end
    chk("R2 div1 stays after rewrite", cnt, 8);

    // R1 R2 R10 sweep rates 1..3
    for (int k = 1; k < 4; k++) begin
      do_reset();
      wr_ctl(mk(0, k, 0, 0));
      first = 0; second = 0;
      for (int n = 1; n <= 40; n++) begin
        cyc(1);
        if (tick_en) begin
          if (first == 0) first = n;
          else if (second == 0) second = n;
        end
      end
      chk("R10 first tick after rate write", first, (1 << k) + 1);
      chk("R1 tick gap", second - first, 1 << k);
      wr_ctl(mk(0, (k + 1) % 4, 0, 0));
      rd(2'd0, rv);
      chk("R2 rate locked readback", rv[2:1], k);
      cnt = 0;
      for (int n = 0; n < 16; n++) begin cyc(1); cnt += tick_en; end
      chk("R2 period unchanged", cnt, 16 >> k);
    end

    // R2 reset re-arms the lock
    do_reset();
    wr_ctl(mk(0, 3, 0, 0));
    rd(2'd0, rv);
    chk("R2 rearm after reset", rv[2:1], 3);

    // R3 clock select
    wr_ctl(mk(0, 0, 1, 0));
    chk("R3 bin_timing set", bin_timing, 1);
    rd(2'd0, rv);
    chk("R3 readback bit3", rv, 8'h0E);
    wr_ctl(mk(0, 0, 0, 0));
    chk("R3 bin_timing clear", bin_timing, 0);
    // R9 other address
    wr_ctl(mk(1, 0, 1, 0));
    rd(2'd1, rv);
    chk("R9 other address", rv, 0);
    rd(2'd3, rv);
    chk("R9 other address", rv, 0);

    // R7 R8 exhaustive gating sweep
    do_reset();
    for (int ie = 0; ie < 2; ie++) begin
      wr_ctl(mk(ie, 0, 0, 0));
      for (int lp = 0; lp < 2; lp++) begin
        for (int s = 0; s < 8; s++) begin
          lp_mode = lp[0]; src_flags = s[2:0];
          cyc(1);
          chk("R7 irq gating", irq, (s != 0 && (ie != 0 || lp != 0)) ? 1 : 0);
          chk("R4 status follows", status_flags, s);
        end
      end
    end
    lp_mode = 1'b0;

    // R8 hold until all sources clear
    src_flags = 3'b011; cyc(1);
    chk("R8 irq raised", irq, 1);
    src_flags = 3'b001; cyc(1);
    chk("R8 irq held", irq, 1);
    src_flags = 3'b000; cyc(1);
    chk("R8 irq dropped", irq, 0);
    src_flags = 3'b101; cyc(1);
    chk("R8 irq before ie clear", irq, 1);
    wr_ctl(mk(0, 0, 0, 0));
    cyc(1);
    chk("R8 irq dropped on ie clear", irq, 0);

    // R4 R6 ignore
    wr_ctl(mk(1, 0, 0, 0));
    src_flags = 3'b111;
    wr_ctl(mk(1, 0, 0, 1));
    chk("R4 rx_enable low", rx_enable, 0);
    cyc(1);
    chk("R6 irq masked", irq, 0);
    chk("R4 status held", status_flags, 0);
    rd(2'd0, rv);
    chk("R9 ignore readback", rv, 8'h11);
    for (int lp = 0; lp < 2; lp++) begin
      for (int s = 0; s < 8; s++) begin
        lp_mode = lp[0]; src_flags = s[2:0];
        cyc(1);
        chk("R6 irq masked sweep", irq, 0);
        chk("R4 status held sweep", status_flags, 0);
      end
    end
    lp_mode = 1'b0; src_flags = 3'b111;

    // R5 start-of-frame clears
    sof_det = 1'b1; cyc(1); sof_det = 1'b0;
    chk("R5 sof clears ignore", rx_enable, 1);
    chk("R5 status still held", status_flags, 0);
    cyc(1);
    chk("R5 status resumes", status_flags, 7);
    chk("R5 irq resumes", irq, 1);
    // R5 break clears
    wr_ctl(mk(1, 0, 0, 1));
    chk("R4 rx_enable low again", rx_enable, 0);
    brk_det = 1'b1; cyc(1); brk_det = 1'b0;
    chk("R5 brk clears ignore", rx_enable, 1);
    cyc(1);
    chk("R5 status after brk", status_flags, 7);
    // R5 clear wins over same-cycle write
    cpu_addr = 2'd0; cpu_wdata = mk(1, 0, 0, 1); cpu_wr = 1'b1; sof_det = 1'b1;
    cyc(1);
    cpu_wr = 1'b0; sof_det = 1'b0;
    chk("R5 clear priority", rx_enable, 1);
    rd(2'd0, rv);
    chk("R5 clear priority readback", rv[4], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule